// File: doc/BRIEF.md
# Setup Command Capture Buffer

This block stores the single setup command of a control endpoint: eight bytes pushed one at a time by the receive engine. A reception is framed by a start strobe, a byte-push strobe with data, and either a good-end or a bad-end strobe. When exactly eight bytes arrive and the frame ends good, the command is marked valid and a sticky setup-received flag is raised for firmware. Firmware clears that flag by writing one to it.

Firmware reads the command through a read-only byte port. Each read request returns the next byte, with a read-valid pulse, one cycle later. An incoming command always has priority over the reader. A new reception overwrites any unread content. If the reception starts while firmware is partway through a command, the read is aborted: the read pointer returns to byte 0 and a sticky read-invalid bit is raised. A rewind request from firmware clears that bit and restarts the read at byte 0.

Top module: `setup_cmd_buf`

## Requirements
- R1: After synchronous reset, setup_flag, cmd_valid, rd_valid and rd_invalid are all 0.
- R2: A frame of start, exactly 8 pushes and a good end sets setup_flag and cmd_valid on the clock edge that samples the good-end strobe.
- R3: While cmd_valid is 1 and no reception is active, each rd_req returns the next stored byte on rd_data with rd_valid high one cycle after the request, starting with the first byte pushed.
- R4: A newly captured command replaces unread content, so the reads that follow return only the new bytes.
- R5: An rx_start that arrives after 1 to 7 bytes have been read sets rd_invalid on the next edge and returns the read position to byte 0.
- R6: rd_rewind clears rd_invalid and restarts reading at byte 0, unless the same edge also aborts a partial read.
- R7: rd_req gives no rd_valid while a reception is active, in the cycle of rx_start, or while cmd_valid is 0.
- R8: A frame that ends with the bad-end strobe, or that holds a byte count other than 8, leaves setup_flag unchanged and cmd_valid at 0.
- R9: Asserting flag_clr clears setup_flag. A completion on the same edge wins, and a later completion sets the flag again.
- R10: Once all 8 bytes have been read, further rd_req produce no rd_valid until a rewind or a new command.
- R11: rx_start clears cmd_valid on the next edge, and the content stays invalid until a good 8-byte frame completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Start of a setup reception |
| rx_push | input | 1 | Byte strobe from the receive engine |
| rx_data | input | DW | Received byte |
| rx_good | input | 1 | Frame ended without error |
| rx_bad | input | 1 | Frame ended with an error |
| flag_clr | input | 1 | Write-one-to-clear for setup_flag |
| rd_req | input | 1 | Firmware byte read request |
| rd_rewind | input | 1 | Restart the read at byte 0 and clear rd_invalid |
| rd_data | output | DW | Byte returned by the last accepted read |
| rd_valid | output | 1 | rd_data holds a byte from an accepted read |
| rd_invalid | output | 1 | Sticky: a read in progress was aborted |
| cmd_valid | output | 1 | Buffer holds a complete, good command |
| setup_flag | output | 1 | Sticky setup-received status |

## Verification
Good 8-byte frames with distinct byte patterns are read back in full. This checks byte order, and a second unread frame checks that new content overwrites old. A reception started after three bytes have been read separates a correct abort (rd_invalid set, read pointer at 0) from a reader that resumes at its old position. Bad-ended, 7-byte and 9-byte frames separate the length and error checks from plain completion. Reads attempted during reception and after the last byte, and a flag clear on the same edge as a completion, cover the priority cases.

// File: rtl/setup_buf_pkg.sv
package setup_buf_pkg;
  typedef struct packed {
    logic start;
    logic push;
    logic good;
    logic bad;
  } rx_evt_t;
endpackage

// File: rtl/sb_store.sv
module sb_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sb_rx_ctrl.sv
module sb_rx_ctrl
  import setup_buf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  rx_evt_t       ev,
  input  logic          flag_clr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          active,
  output logic          cmd_valid,
  output logic          setup_flag
);
  logic [CW-1:0] cnt;
  logic          ending;
  logic          complete;

  assign ending   = ev.good | ev.bad;
  assign complete = active && ev.good && !ev.start && (cnt == CW'(DEPTH));
  assign we       = active && ev.push && !ending && !ev.start && (cnt < CW'(DEPTH));
  assign waddr    = cnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      cnt       <= '0;
      cmd_valid <= 1'b0;
    end else if (ev.start) begin
      active    <= 1'b1;
      cnt       <= '0;
      cmd_valid <= 1'b0;
    end else if (active && ending) begin
      active    <= 1'b0;
      cmd_valid <= complete;
    end else if (active && ev.push && (cnt <= CW'(DEPTH))) begin
      cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           setup_flag <= 1'b0;
    else if (complete) setup_flag <= 1'b1;
    else if (flag_clr) setup_flag <= 1'b0;
  end

  a_r2_flag_on_complete: assert property (@(posedge clk) disable iff (rst)
    complete |=> (setup_flag && cmd_valid));
  a_r8_flag_source: assert property (@(posedge clk) disable iff (rst)
    $rose(setup_flag) |-> $past(ev.good && cnt == CW'(DEPTH)));
  a_r11_start_clears: assert property (@(posedge clk) disable iff (rst)
    ev.start |=> (!cmd_valid && active));
  a_r8_valid_idle: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !active);
endmodule

// File: rtl/sb_rd_ctrl.sv
module sb_rd_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  logic          rd_rewind,
  input  logic          rx_start,
  input  logic          rx_active,
  input  logic          cmd_valid,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic          rd_valid,
  output logic          rd_invalid
);
  logic [PW-1:0] ptr;
  logic          midway;

  assign midway = (ptr != '0) && (ptr != PW'(DEPTH));
  assign re     = rd_req && cmd_valid && !rx_active && !rx_start && (ptr < PW'(DEPTH));
  assign raddr  = ptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr        <= '0;
      rd_valid   <= 1'b0;
      rd_invalid <= 1'b0;
    end else begin
      rd_valid <= re;
      if (rx_start || rd_rewind) ptr <= '0;
      else if (re)               ptr <= ptr + PW'(1);
      if (rx_start && midway)    rd_invalid <= 1'b1;
      else if (rd_rewind)        rd_invalid <= 1'b0;
    end
  end

  a_r5_abort_marks: assert property (@(posedge clk) disable iff (rst)
    (rx_start && midway) |=> (rd_invalid && ptr == '0));
  a_r6_rewind_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_rewind && !(rx_start && midway)) |=> (!rd_invalid && ptr == '0));
  a_r7_read_gate: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(cmd_valid && !rx_active && !rx_start));
  a_r10_ptr_bound: assert property (@(posedge clk) disable iff (rst)
    ptr <= PW'(DEPTH));
endmodule

// File: rtl/setup_cmd_buf.sv
module setup_cmd_buf
  import setup_buf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_start,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_good,
  input  logic          rx_bad,
  input  logic          flag_clr,
  input  logic          rd_req,
  input  logic          rd_rewind,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_invalid,
  output logic          cmd_valid,
  output logic          setup_flag
);
  rx_evt_t       ev;
  logic          we, re, active;
  logic [AW-1:0] waddr, raddr;

  assign ev = '{start: rx_start, push: rx_push, good: rx_good, bad: rx_bad};

  sb_rx_ctrl #(.DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst(rst), .ev(ev), .flag_clr(flag_clr),
    .we(we), .waddr(waddr), .active(active),
    .cmd_valid(cmd_valid), .setup_flag(setup_flag)
  );

  sb_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_rewind(rd_rewind),
    .rx_start(rx_start), .rx_active(active), .cmd_valid(cmd_valid),
    .re(re), .raddr(raddr), .rd_valid(rd_valid), .rd_invalid(rd_invalid)
  );

  sb_store #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(rx_data),
    .re(re), .raddr(raddr), .rdata(rd_data)
  );

  a_r7_no_read_in_rx: assert property (@(posedge clk) disable iff (rst)
    (rx_start || active) |=> !rd_valid);
endmodule

// File: tb/sim_setup_cmd_buf.sv
`timescale 1ns/1ps
module sim_setup_cmd_buf;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_start = 0, rx_push = 0, rx_good = 0, rx_bad = 0;
  logic [7:0] rx_data = '0;
  logic       flag_clr = 0, rd_req = 0, rd_rewind = 0;
  logic [7:0] rd_data;
  logic       rd_valid, rd_invalid, cmd_valid, setup_flag;
  int         n_tests = 0, n_fail = 0, cycles = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  setup_cmd_buf u0 (
    .clk(clk), .rst(rst), .rx_start(rx_start), .rx_push(rx_push),
    .rx_data(rx_data), .rx_good(rx_good), .rx_bad(rx_bad),
    .flag_clr(flag_clr), .rd_req(rd_req), .rd_rewind(rd_rewind),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_invalid(rd_invalid),
    .cmd_valid(cmd_valid), .setup_flag(setup_flag)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // start, n pushes of base+i, then good or bad end; outputs checked after the end edge
  task automatic send(int base, int n, bit good);
    rx_start = 1; tick(); rx_start = 0;
    for (int i = 0; i < n; i++) begin
      rx_push = 1; rx_data = 8'(base + i); tick();
    end
    rx_push = 0;
    if (good) rx_good = 1; else rx_bad = 1;
    tick();
    rx_good = 0; rx_bad = 0;
  endtask

  task automatic read_one(string req, bit exp_v, int exp_d);
    rd_req = 1; tick(); rd_req = 0;
    check(req, rd_valid, exp_v);
    if (exp_v) check(req, rd_data, exp_d);
  endtask

  task automatic t_reset();
    check("R1 flag", setup_flag, 0);
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 rd_valid", rd_valid, 0);
    check("R1 rd_invalid", rd_invalid, 0);
  endtask

  task automatic t_capture_read();
    send(8'h10, 8, 1);
    check("R2 flag", setup_flag, 1);
    check("R2 cmd_valid", cmd_valid, 1);
    for (int i = 0; i < 8; i++) read_one("R3 byte", 1, 8'h10 + i);
    read_one("R10 past end", 0, 0);
    read_one("R10 past end again", 0, 0);
  endtask

  task automatic t_flag_and_overwrite();
    flag_clr = 1; tick(); flag_clr = 0;
    check("R9 cleared", setup_flag, 0);
    send(8'h40, 8, 1);
    check("R9 sets again", setup_flag, 1);
    send(8'h80, 8, 1);
    rd_rewind = 1; tick(); rd_rewind = 0;
    for (int i = 0; i < 8; i++) read_one("R4 overwrite", 1, 8'h80 + i);
  endtask

  task automatic t_abort();
    rd_rewind = 1; tick(); rd_rewind = 0;
    for (int i = 0; i < 3; i++) read_one("R3 partial", 1, 8'h80 + i);
    check("R5 before abort", rd_invalid, 0);
    rx_start = 1; tick(); rx_start = 0;
    check("R5 abort", rd_invalid, 1);
    check("R11 start clears", cmd_valid, 0);
    read_one("R7 read during rx", 0, 0);
    for (int i = 0; i < 8; i++) begin
      rx_push = 1; rx_data = 8'(8'hC0 + i); tick();
    end
    rx_push = 0; rx_good = 1; tick(); rx_good = 0;
    check("R5 sticky", rd_invalid, 1);
    check("R2 cmd_valid after abort", cmd_valid, 1);
    // pointer went back to 0 at the abort: first read gives byte 0
    read_one("R5 ptr reset", 1, 8'hC0);
    rd_rewind = 1; tick(); rd_rewind = 0;
    check("R6 rewind clears", rd_invalid, 0);
    for (int i = 0; i < 8; i++) read_one("R6 reread", 1, 8'hC0 + i);
    // fully read then new rx: not an abort
    send(8'h20, 8, 1);
    check("R5 no abort when done", rd_invalid, 0);
  endtask

  task automatic t_bad_frames();
    flag_clr = 1; tick(); flag_clr = 0;
    send(8'h30, 8, 0);
    check("R8 bad flag", setup_flag, 0);
    check("R8 bad valid", cmd_valid, 0);
    read_one("R7 read invalid content", 0, 0);
    send(8'h30, 7, 1);
    check("R8 short flag", setup_flag, 0);
    check("R8 short valid", cmd_valid, 0);
    send(8'h30, 9, 1);
    check("R8 long flag", setup_flag, 0);
    check("R11 long valid", cmd_valid, 0);
  endtask

  task automatic t_clr_vs_set();
    rx_start = 1; tick(); rx_start = 0;
    for (int i = 0; i < 8; i++) begin
      rx_push = 1; rx_data = 8'(8'h50 + i); tick();
    end
    rx_push = 0; rx_good = 1; flag_clr = 1; tick();
    rx_good = 0; flag_clr = 0;
    check("R9 set wins", setup_flag, 1);
    read_one("R3 after clr race", 1, 8'h50);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0; tick();
    t_reset();
    t_capture_read();
    t_flag_and_overwrite();
    t_abort();
    t_bad_frames();
    t_clr_vs_set();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule